// File: doc/BRIEF.md
# Oversampling Chopper Result Accumulator

This block sits between an analog-to-digital converter and the sequencer that collects its conversions. It takes 10-bit raw samples on a valid/ready stream and sums a power-of-two number of them, selected by a 3-bit sample-count code. It then scales the sum into a 16-bit field that is packed from the top bit down. The upper ten bits of that field always carry meaning. Each doubling of the sample count adds one more meaningful low bit, so 64 or more samples fill the field.

With chopping enabled, the block flips a polarity output after every sample it accepts. This tells the analog side to invert the next conversion at both its input and its output. A sample taken under inverted polarity is ones'-complemented within 10 bits before it is summed, so the converter's internal offset cancels across each pair. Chopping with a code of 0 still takes two samples, so that every result holds one complete pair.

The result leaves on a second valid/ready stream. While a finished result waits for the sequencer, the sample input reports not-ready. The result register keeps its last value between results. A restart pulse abandons a partial sum.

Top module: `chop_oversample_acc`

## Requirements
- R1: After reset, `m_valid` is 0, `m_data` is 0, `sign_o` is 0 and `s_ready` is 1.
- R2: A sample is accepted on a rising clock edge where `s_valid` and `s_ready` are both 1. A result is produced after 2^n accepted samples, where n is the effective count code. The value of `m_data` becomes visible, with `m_valid` = 1, one clock after the edge that accepts the last sample.
- R3: When `code_i` = 0 and `chop_i` = 1, the effective code is 1, so the block takes two samples. In every other case the effective code equals `code_i`.
- R4: `sign_o` is 0 (normal polarity) at the start of every sequence, after a result and after a restart. With chopping on, it inverts after every accepted sample that does not complete the sequence. With chopping off, it stays 0.
- R5: A sample accepted while `sign_o` = 1 is added as its 10-bit ones' complement (1023 − value). A sample accepted while `sign_o` = 0 is added unchanged.
- R6: With effective code n and sum S, the result is S shifted left by (6 − n) for n ≤ 6. For n = 7 it is S shifted right by 1, with the dropped bit discarded.
- R7: While `m_valid` = 1 and `m_ready` = 0, `m_valid` stays 1 and `m_data` does not change. `s_ready` is 0 whenever `m_valid` is 1 or `restart` is 1.
- R8: `m_data` changes only when a new result is presented. After the sequencer takes a result, `m_data` keeps that value.
- R9: A `restart` pulse clears the partial sum, the sample count and `sign_o`. The next accepted sample begins a fresh sequence.
- R10: `code_i` and `chop_i` are captured at the first sample of a sequence. Changes to them before the sequence completes have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Abandon the current partial sequence |
| code_i | input | 3 | Sample-count code n (2^n samples) |
| chop_i | input | 1 | Chopping enable |
| s_valid | input | 1 | Raw sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_data | input | 10 | Raw converter sample |
| sign_o | output | 1 | Polarity for the next conversion (1 = inverted) |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Sequencer accepts the result |
| m_data | output | 16 | Left-aligned accumulated result |

## Verification
The assertions assume that `restart` is a synchronous pulse and that the sequencer follows the valid/ready rules, that is, it never relies on a sample being taken while `s_ready` is 0. The bench drives every input on the falling clock edge. It raises `s_valid` for a directed sample only after it has seen `s_ready` high, and it keeps `restart` low during those transfers. It also applies random back-pressure, restarts and mid-sequence changes to the code and chop inputs. A behavioural model accepts or ignores these inputs by the same port-level rules.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
  typedef enum logic {POL_NORM = 1'b0, POL_INV = 1'b1} pol_e;

  // Chopping needs at least one complete pair of samples.
  function automatic logic [2:0] eff_code3(input logic [2:0] code, input logic chop);
    return (code == 3'd0 && chop) ? 3'd1 : code;
  endfunction
endpackage

// File: rtl/ocr_seq.sv
module ocr_seq #(
  parameter int CODE_W = 3,
  localparam int MAXC  = (1 << CODE_W) - 1,
  localparam int CNT_W = MAXC + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              accept,
  input  logic [CODE_W-1:0] code_in,
  input  logic              chop_in,
  output logic [CODE_W-1:0] code_cur,
  output logic              chop_cur,
  output logic              last,
  output ocr_pkg::pol_e     pol
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic              chop_q;
  logic              first;
  logic [CODE_W-1:0] code_live;
  logic [CNT_W-1:0]  target;

  assign first = (cnt_q == '0);

  always_comb begin
    code_live = code_in;
    if (code_in == '0 && chop_in) code_live = CODE_W'(1);
  end

  assign code_cur = first ? code_live : code_q;
  assign chop_cur = first ? chop_in   : chop_q;
  assign target   = CNT_W'(1) << code_cur;
  assign last     = (cnt_q + CNT_W'(1)) == target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
      chop_q <= 1'b0;
      pol    <= ocr_pkg::POL_NORM;
    end else if (restart) begin
      cnt_q <= '0;
      pol   <= ocr_pkg::POL_NORM;
    end else if (accept) begin
      if (first) begin
        code_q <= code_live;
        chop_q <= chop_in;
      end
      if (last) begin
        cnt_q <= '0;
        pol   <= ocr_pkg::POL_NORM;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (chop_cur)
          pol <= (pol == ocr_pkg::POL_NORM) ? ocr_pkg::POL_INV : ocr_pkg::POL_NORM;
      end
    end
  end
endmodule

// File: rtl/ocr_acc.sv
module ocr_acc #(
  parameter int SAMPLE_W = 10,
  parameter int CODE_W   = 3,
  localparam int ACC_W   = SAMPLE_W + (1 << CODE_W) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                accept,
  input  logic                last,
  input  ocr_pkg::pol_e       pol,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [ACC_W-1:0]    sum_next
);
  logic [ACC_W-1:0]    acc_q;
  logic [SAMPLE_W-1:0] corrected;

  assign corrected = (pol == ocr_pkg::POL_INV) ? ~sample : sample;
  assign sum_next  = acc_q + ACC_W'(corrected);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   acc_q <= '0;
    else if (restart)             acc_q <= '0;
    else if (accept && last)      acc_q <= '0;
    else if (accept)              acc_q <= sum_next;
  end
endmodule

// File: rtl/ocr_out.sv
module ocr_out #(
  parameter int SAMPLE_W = 10,
  parameter int RESULT_W = 16,
  parameter int CODE_W   = 3,
  localparam int NCODES  = 1 << CODE_W,
  localparam int ACC_W   = SAMPLE_W + NCODES - 1,
  localparam int EXTRA   = RESULT_W - SAMPLE_W,
  localparam int WIDE_W  = ACC_W + RESULT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic [CODE_W-1:0]   code_cur,
  input  logic [ACC_W-1:0]    sum,
  input  logic                m_ready,
  output logic                m_valid,
  output logic [RESULT_W-1:0] m_data
);
  logic [RESULT_W-1:0] scaled [NCODES];
  logic [WIDE_W-1:0]   wide;

  assign wide = WIDE_W'(sum);

  for (genvar k = 0; k < NCODES; k++) begin : g_scale
    if (k <= EXTRA) begin : g_left
      assign scaled[k] = RESULT_W'(wide << (EXTRA - k));
    end else begin : g_right
      assign scaled[k] = RESULT_W'(wide >> (k - EXTRA));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (done) begin
      m_valid <= 1'b1;
      m_data  <= scaled[code_cur];
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/chop_oversample_acc.sv
module chop_oversample_acc #(
  parameter int SAMPLE_W = 10,
  parameter int RESULT_W = 16,
  parameter int CODE_W   = 3,
  localparam int ACC_W   = SAMPLE_W + (1 << CODE_W) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                chop_i,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                sign_o,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [RESULT_W-1:0] m_data
);
  logic              accept;
  logic              last;
  logic              chop_cur;
  logic [CODE_W-1:0] code_cur;
  ocr_pkg::pol_e     pol;
  logic [ACC_W-1:0]  sum_next;

  assign s_ready = !m_valid && !restart;
  assign accept  = s_valid && s_ready;
  assign sign_o  = (pol == ocr_pkg::POL_INV);

  ocr_seq #(.CODE_W(CODE_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .accept(accept),
    .code_in(code_i), .chop_in(chop_i), .code_cur(code_cur),
    .chop_cur(chop_cur), .last(last), .pol(pol)
  );

  ocr_acc #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .accept(accept),
    .last(last), .pol(pol), .sample(s_data), .sum_next(sum_next)
  );

  ocr_out #(.SAMPLE_W(SAMPLE_W), .RESULT_W(RESULT_W), .CODE_W(CODE_W)) out_i (
    .clk(clk), .rst_n(rst_n), .done(accept && last), .code_cur(code_cur),
    .sum(sum_next), .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data)
  );
endmodule

// File: rtl/ocr_chk.sv
module ocr_chk #(
  parameter int RESULT_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                restart,
  input logic                s_ready,
  input logic                sign_o,
  input logic                chop_cur,
  input logic                m_valid,
  input logic                m_ready,
  input logic [RESULT_W-1:0] m_data
);
  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));
  // R7
  no_sample_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);
  // R8
  data_only_on_new_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(m_valid) |-> $stable(m_data));
  // R4
  sign_needs_chop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sign_o |-> chop_cur);
  // R4
  sign_default_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> !sign_o);
  // R9
  restart_clears_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !sign_o);
endmodule

bind chop_oversample_acc ocr_chk #(.RESULT_W(RESULT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .restart(restart), .s_ready(s_ready),
  .sign_o(sign_o), .chop_cur(chop_cur), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data)
);

// File: tb/chop_oversample_acc_tb_top.sv
module chop_oversample_acc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic [2:0] code_i = 3'd0;
  logic       chop_i = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [9:0] s_data = '0;
  logic       sign_o;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [15:0] m_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  chop_oversample_acc dut_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .code_i(code_i),
    .chop_i(chop_i), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .sign_o(sign_o), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  // Behavioural reference: a queue of corrected samples in the current sequence.
  int  q[$];
  int  m_cnt_target = 1;
  int  m_n = 0;
  bit  m_chop = 0;
  bit  m_sign = 0;
  bit  m_valid_m = 0;
  int  m_res = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_sign = 0; m_valid_m = 0; m_res = 0;
    end else begin
      bit take;
      take = s_valid && !m_valid_m && !restart;
      if (m_valid_m && m_ready) m_valid_m = 0;
      if (restart) begin
        q.delete(); m_sign = 0;
      end else if (take) begin
        if (q.size() == 0) begin
          m_n = int'(code_i);
          m_chop = chop_i;
          if (m_n == 0 && m_chop) m_n = 1;
          m_cnt_target = 1 << m_n;
        end
        q.push_back(m_sign ? (1023 - int'(s_data)) : int'(s_data));
        if (q.size() == m_cnt_target) begin
          int s;
          s = 0;
          foreach (q[i]) s += q[i];
          m_res = (m_n <= 6) ? (s * (1 << (6 - m_n))) : (s / (1 << (m_n - 6)));
          m_res = m_res % 65536;
          m_valid_m = 1;
          q.delete();
          m_sign = 0;
        end else if (m_chop) begin
          m_sign = !m_sign;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 m_valid", int'(m_valid), int'(m_valid_m));
      check("R6 m_data", int'(m_data), m_res);
      check("R4 sign_o", int'(sign_o), int'(m_sign));
      check("R7 s_ready", int'(s_ready), int'(!m_valid_m && !restart));
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic send(input int d);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1;
    s_data  = 10'(d);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_res(input string tag, input int exp);
    while (!m_valid) @(negedge clk);
    check(tag, int'(m_data), exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 m_valid", int'(m_valid), 0);
    check("R1 m_data", int'(m_data), 0);
    check("R1 sign_o", int'(sign_o), 0);
    check("R1 s_ready", int'(s_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R6: code 0, no chop, single full-scale sample
    code_i = 3'd0; chop_i = 1'b0;
    send(1023);
    check("R2 one-sample result valid", int'(m_valid), 1);
    wait_res("R6 code0", 16'hFFC0);

    // R3 R5: code 0 with chop takes two samples, second inverted
    chop_i = 1'b1;
    send(100);
    check("R3 no result after first chopped sample", int'(m_valid), 0);
    check("R4 sign inverted after first sample", int'(sign_o), 1);
    send(100);
    wait_res("R5 code0 chop", 16'h7FE0);

    // R4 R5: code 2 chop alternating polarity
    code_i = 3'd2;
    for (int i = 0; i < 4; i++) send(10);
    wait_res("R5 code2 chop", 32736);

    // R6: code 7 truncating right shift
    code_i = 3'd7; chop_i = 1'b0;
    for (int i = 0; i < 127; i++) send(1);
    send(2);
    wait_res("R6 code7 truncation", 64);

    // R7 R8: back-pressure then hold after acceptance
    code_i = 3'd1;
    m_ready = 1'b0;
    send(300); send(200);
    for (int i = 0; i < 3; i++) begin
      check("R7 held valid", int'(m_valid), 1);
      check("R7 held data", int'(m_data), 500 * 32);
      check("R7 s_ready low", int'(s_ready), 0);
      @(negedge clk);
    end
    m_ready = 1'b1;
    @(negedge clk);
    check("R8 valid dropped", int'(m_valid), 0);
    check("R8 data kept", int'(m_data), 500 * 32);

    // R9: restart clears partial sum and polarity
    chop_i = 1'b1;
    send(500);
    check("R4 sign before restart", int'(sign_o), 1);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check("R9 sign cleared", int'(sign_o), 0);
    send(3); send(5);
    wait_res("R9 fresh sequence", 1021 * 32);

    // R10: configuration captured at first sample
    code_i = 3'd1; chop_i = 1'b0;
    send(7);
    code_i = 3'd3; chop_i = 1'b1;
    send(9);
    wait_res("R10 mid-sequence change ignored", 512);

    // Random phase, compared against the model every clock
    for (int i = 0; i < 4000; i++) begin
      s_valid = ($urandom % 4) != 0;
      s_data  = 10'($urandom);
      m_ready = ($urandom % 3) != 0;
      restart = ($urandom % 97) == 0;
      if ($urandom % 25 == 0) code_i = 3'($urandom % 5);
      if ($urandom % 25 == 0) chop_i = 1'($urandom);
      @(negedge clk);
    end
    s_valid = 1'b0; restart = 1'b0; m_ready = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule